// File: doc/BRIEF.md
# Single Outstanding Transaction Monitor

This block watches a request/response interface on which at most one transaction may be open at any time. A request handshake is a cycle in which the request valid and ready are both high. A response handshake is a cycle in which the response valid and ready are both high. A transaction opens on a request handshake and closes in the first cycle after its response in which the response handshake is no longer present. The monitor reports protocol violations and counts the transactions that close legally.

The block is passive. It is wired next to an address/data pair of handshakes, for example the address and data phases of a memory read port. It drives nothing back into the interface. `busy` shows whether a transaction is open. `errPulse` marks each violation for one cycle. `errSticky` holds until reset. `errCode` keeps the kind of the most recent violation. `txnCount` counts legally closed transactions and wraps at its width.

Top module: `solo_txn_monitor`

## Requirements
- R1: A request counts only in a cycle where reqValid and reqReady are both high. A response counts only in a cycle where rspValid and rspReady are both high. A valid without its ready, or a ready without its valid, changes no output.
- R2: After reset, busy rises in the cycle after a request handshake. It stays high until the transaction closes and is low in the cycle after the closing cycle.
- R3: A response handshake in the same cycle as the request that opens a transaction does not answer that transaction. Only a response in a later cycle moves the transaction forward.
- R4: After its response, a transaction closes in the first cycle in which the response handshake is absent. txnCount rises by exactly 1 in the following cycle. A response held high for several cycles still yields a single close.
- R5: A request handshake while busy is high is an overlap violation. This includes the cycle that would otherwise close the transaction. The next cycle shows errPulse high and errCode equal to 1. The new request becomes the open transaction and waits for a response of its own. The old transaction is not counted.
- R6: A response handshake while busy is low is a stray violation. This holds even if a request handshake occurs in the same cycle. The next cycle shows errPulse high and errCode equal to 2. A request in that cycle still opens a transaction.
- R7: errPulse is high for one cycle per violating cycle. errSticky rises with the first errPulse and stays high until reset. errCode holds the code of the latest violation: 0 none, 1 overlap, 2 stray.
- R8: During and right after reset, busy, errPulse and errSticky are 0, errCode is 0 and txnCount is 0.
- R9: Any number of idle cycles may separate a request, its response, the response drop and the next request, with no violation reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid |
| reqReady | input | 1 | Request ready |
| rspValid | input | 1 | Response valid |
| rspReady | input | 1 | Response ready |
| busy | output | 1 | A transaction is open |
| errPulse | output | 1 | One-cycle violation marker |
| errSticky | output | 1 | A violation has occurred since reset |
| errCode | output | 2 | Latest violation code: 0 none, 1 overlap, 2 stray |
| txnCount | output | CNT_W | Count of legally closed transactions |

## Verification
A request handshake and a response handshake can arrive in the same cycle, and what that cycle means depends on the monitor's state. With no transaction open, the response is a stray violation while the request still opens a transaction. With a transaction open, the request is an overlap violation that takes priority, and the response is discarded. In the closing cycle, the same collision cancels the close. The bench drives every sequence of five cycles over the four request/response handshake combinations from reset, which provokes the collision in every state. It judges each cycle against a two-flag model of open and answered state, checking busy, the error outputs and the counter.

// File: rtl/solo_txn_pkg.sv
package solo_txn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_RSP = 2'd1,
    ST_WAIT_LOW = 2'd2
  } txnState_t;

  typedef struct packed {
    logic closeTxn;
    logic errOverlap;
    logic errStray;
  } ctrlStrobe_t;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_NONE    = 2'd0;
  localparam logic [CODE_W-1:0] CODE_OVERLAP = 2'd1;
  localparam logic [CODE_W-1:0] CODE_STRAY   = 2'd2;

endpackage

// File: rtl/solo_txn_ctrl.sv
module solo_txn_ctrl
  import solo_txn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqReady,
  input  logic        rspValid,
  input  logic        rspReady,
  output ctrlStrobe_t strobe,
  output logic        busy
);

  txnState_t state, nxtState;
  logic reqHs, rspHs;

  // R1: handshakes need both halves
  assign reqHs = reqValid & reqReady;
  assign rspHs = rspValid & rspReady;

  always_comb begin
    nxtState = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        // R6: a response with nothing open
        if (rspHs) strobe.errStray = 1'b1;
        // R3: the opening cycle's response is not the answer
        if (reqHs) nxtState = ST_WAIT_RSP;
      end
      ST_WAIT_RSP: begin
        if (reqHs) begin
          strobe.errOverlap = 1'b1;   // R5: new request replaces the open one
          nxtState = ST_WAIT_RSP;
        end else if (rspHs) begin
          nxtState = ST_WAIT_LOW;
        end
      end
      ST_WAIT_LOW: begin
        if (reqHs) begin
          strobe.errOverlap = 1'b1;   // R5: even in the would-be closing cycle
          nxtState = ST_WAIT_RSP;
        end else if (!rspHs) begin
          strobe.closeTxn = 1'b1;     // R4
          nxtState = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/solo_txn_dp.sv
module solo_txn_dp
  import solo_txn_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic              errPulse,
  output logic              errSticky,
  output logic [CODE_W-1:0] errCode,
  output logic [CNT_W-1:0]  txnCount
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic anyErr;
  assign anyErr = strobe.errOverlap | strobe.errStray;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse  <= 1'b0;
      errSticky <= 1'b0;
      errCode   <= CODE_NONE;
      txnCount  <= '0;
    end else begin
      errPulse  <= anyErr;
      errSticky <= errSticky | anyErr;
      if (strobe.errOverlap)    errCode <= CODE_OVERLAP;
      else if (strobe.errStray) errCode <= CODE_STRAY;
      if (strobe.closeTxn)      txnCount <= txnCount + CNT_ONE;
    end
  end

endmodule

// File: rtl/solo_txn_monitor.sv
module solo_txn_monitor
  import solo_txn_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqReady,
  input  logic              rspValid,
  input  logic              rspReady,
  output logic              busy,
  output logic              errPulse,
  output logic              errSticky,
  output logic [1:0]        errCode,
  output logic [CNT_W-1:0]  txnCount
);

  ctrlStrobe_t strobe;

  solo_txn_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .strobe(strobe), .busy(busy)
  );

  solo_txn_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .errPulse(errPulse), .errSticky(errSticky),
    .errCode(errCode), .txnCount(txnCount)
  );

endmodule

// File: rtl/solo_txn_monitor_chk.sv
module solo_txn_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspReady,
  input logic             busy,
  input logic             errPulse,
  input logic             errSticky,
  input logic [1:0]       errCode,
  input logic [CNT_W-1:0] txnCount
);

  logic reqHs, rspHs;
  assign reqHs = reqValid && reqReady;
  assign rspHs = rspValid && rspReady;

  // R2
  busy_opens_on_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqHs));

  // R4
  count_steps_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txnCount != $past(txnCount)) |-> (txnCount == $past(txnCount) + CNT_W'(1)) && !busy);

  // R5
  overlap_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqHs) |=> (errPulse && errCode == 2'd1 && busy));

  // R6
  stray_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && rspHs) |=> (errPulse && errCode == 2'd2));

  // R7
  sticky_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(errSticky));

  // R7
  pulse_implies_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> errSticky);

endmodule

bind solo_txn_monitor solo_txn_monitor_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN),
  .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspReady(rspReady),
  .busy(busy), .errPulse(errPulse), .errSticky(errSticky),
  .errCode(errCode), .txnCount(txnCount)
);

// File: tb/sim_solo_txn_monitor.sv
`timescale 1ns/1ps
module sim_solo_txn_monitor;

  localparam int CNT_W = 16;
  localparam int STEPS = 5;
  localparam int SEQS  = 1 << (2 * STEPS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady = 1'b0, rspValid = 1'b0, rspReady = 1'b0;
  logic busy, errPulse, errSticky;
  logic [1:0] errCode;
  logic [CNT_W-1:0] txnCount;

  int vecCnt = 0;
  int failCnt = 0;

  // model state
  bit mOpen, mAnswered, mPulse, mSticky;
  logic [1:0] mCode;
  logic [CNT_W-1:0] mCount;

  always #4 clk = ~clk;

  solo_txn_monitor #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .busy(busy), .errPulse(errPulse), .errSticky(errSticky),
    .errCode(errCode), .txnCount(txnCount)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string ctx);
    string codeTag;
    codeTag = (mCode == 2'd1) ? "R5" : (mCode == 2'd2) ? "R6" : "R7";
    check("R2", {ctx, " busy"}, busy, mOpen);
    check("R7", {ctx, " errPulse"}, errPulse, mPulse);
    check("R7", {ctx, " errSticky"}, errSticky, mSticky);
    check(codeTag, {ctx, " errCode"}, errCode, mCode);
    check("R4", {ctx, " txnCount"}, txnCount, mCount);
  endtask

  // Reference built from the requirements: open flag plus answered flag.
  task automatic modelStep(input bit req, input bit rsp);
    bit err; logic [1:0] code;
    err = 1'b0; code = 2'd0;
    if (!mOpen) begin
      if (rsp) begin err = 1'b1; code = 2'd2; end      // R6
      if (req) begin mOpen = 1'b1; mAnswered = 1'b0; end // R3: same-cycle rsp ignored
    end else if (req) begin
      err = 1'b1; code = 2'd1; mAnswered = 1'b0;         // R5
    end else if (!mAnswered) begin
      if (rsp) mAnswered = 1'b1;
    end else if (!rsp) begin
      mOpen = 1'b0; mAnswered = 1'b0; mCount = mCount + 1'b1; // R4
    end
    mPulse = err;
    if (err) begin mSticky = 1'b1; mCode = code; end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    {reqValid, reqReady, rspValid, rspReady} = 4'b0;
    @(posedge clk);
    @(negedge clk);
    mOpen = 0; mAnswered = 0; mPulse = 0; mSticky = 0; mCode = 0; mCount = 0;
    checkAll("R8 reset");
    rstN = 1'b1;
  endtask

  // R1, R3, R9: every 5-cycle pattern of {request, response} handshakes,
  // with non-handshake cycles showing half-handshakes (valid only, ready only, none)
  initial begin
    for (int s = 0; s < SEQS; s++) begin
      doReset();
      for (int k = 0; k < STEPS; k++) begin
        bit req, rsp;
        int vq, vr;
        req = bit'((s >> (2 * k)) & 1);
        rsp = bit'((s >> (2 * k + 1)) & 1);
        vq = (s + k) % 3;
        vr = (s + 2 * k + 1) % 3;
        reqValid = req ? 1'b1 : (vq == 0);
        reqReady = req ? 1'b1 : (vq == 1);
        rspValid = rsp ? 1'b1 : (vr == 0);
        rspReady = rsp ? 1'b1 : (vr == 1);
        @(posedge clk);
        @(negedge clk);
        modelStep(req, rsp);
        checkAll($sformatf("seq %0d step %0d", s, k));
      end
    end
    // R9: long gaps between every phase, several legal transactions
    doReset();
    for (int t = 0; t < 4; t++) begin
      for (int ph = 0; ph < 3; ph++) begin
        {reqValid, reqReady, rspValid, rspReady} = 4'b0;
        if (ph == 0) {reqValid, reqReady} = 2'b11;
        if (ph == 1) {rspValid, rspReady} = 2'b11;
        @(posedge clk); @(negedge clk);
        modelStep(ph == 0, ph == 1);
        {reqValid, reqReady, rspValid, rspReady} = 4'b0;
        for (int g = 0; g < 7 + t; g++) begin
          @(posedge clk); @(negedge clk);
          modelStep(1'b0, 1'b0);
        end
        checkAll($sformatf("R9 gap txn %0d phase %0d", t, ph));
      end
    end
    check("R9", "final count after gapped transactions", txnCount, 4);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

endmodule